// File: doc/BRIEF.md
# Pulse-Coded Isolation Channel with Watchdog

This block models one data channel of a pulse-coded isolator as two halves in one clocked design. The transmit half brings a logic input into the clock domain and turns each change of level into a single-cycle pulse. A set pulse marks a high level and a clear pulse marks a low level. When the input stays quiet, the transmitter resends its present level at a fixed interval. The output therefore stays right at DC even if a pulse is lost.

The receive half holds a bistable output that follows the pulses it gets. If no pulse arrives for a watchdog interval, it decides that the transmit side has lost power. It then drives the output to a default level chosen on an input pin. The two halves meet only at the pulse pair. The transmit pulses come out on ports and the receive pulses go in on ports, so an integrator joins them or models the barrier between them. Both intervals are parameters given in clock cycles.

Top module: `iso_pulse_link`

## Requirements
- R1: While rst_n is low, tx_set and tx_clr are 0 and dout equals dflt_lvl.
- R2: After reset is released, the transmitter sends one pulse for the present din level. The pulse is visible in the cycle after the third rising clock edge. It is tx_set if din is 1 and tx_clr if din is 0.
- R3: Suppose din changes just after rising edge c. Then a pulse for the new level is visible in the cycle after edge c+3: tx_set for a rise, tx_clr for a fall. Any refresh due at edge c+2 or earlier still carries the old level.
- R4: While din has no transition, the transmitter sends a pulse for the present level REFRESH_CYCLES edges after the previous pulse of any kind. It repeats this for as long as din stays idle.
- R5: Each transmit pulse lasts exactly one cycle. tx_set and tx_clr are never high together, and neither is high in two consecutive cycles.
- R6: A receive set pulse (rx_set=1, rx_clr=0) makes dout 1 after the next rising edge. A receive clear pulse (rx_clr=1, rx_set=0) makes dout 0 after the next edge. Between pulses dout holds its value.
- R7: Suppose the last valid receive pulse was taken at edge e and none follows. Then dout still shows the held value after edge e+WATCHDOG_CYCLES-1 and equals dflt_lvl from edge e+WATCHDOG_CYCLES on. While timed out, dout follows any change of dflt_lvl.
- R8: While timed out, a valid receive pulse restores normal operation at the next edge, with dout taken from that pulse. A valid pulse taken on the very edge at which the watchdog would expire also wins over the default.
- R9: A cycle with rx_set and rx_clr both high leaves dout unchanged. It does not count as a pulse for the watchdog.
- R10: WATCHDOG_CYCLES must exceed REFRESH_CYCLES, and REFRESH_CYCLES must be at least 2. Both are checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 1 | Asynchronous logic level to carry |
| dflt_lvl | input | 1 | Level that dout takes when the watchdog has expired |
| tx_set | output | 1 | Single-cycle pulse from the transmitter marking a high level |
| tx_clr | output | 1 | Single-cycle pulse from the transmitter marking a low level |
| rx_set | input | 1 | Set pulse arriving at the receiver |
| rx_clr | input | 1 | Clear pulse arriving at the receiver |
| dout | output | 1 | Output of the receive half |

## Verification
In the receive half, watchdog expiry and the arrival of a valid pulse can fall on the same clock edge. The bench opens the loop between the halves and drives the receive pins itself. It places a set pulse exactly WATCHDOG_CYCLES edges after the previous one, with dflt_lvl at 0. It then requires dout to be 1 on that edge, which shows that the pulse wins. In the transmit half, a scheduled refresh and a freshly synchronized input change can fall on neighbouring edges. The bench changes din so that the refresh at edge c+2 and the change pulse at edge c+3 come back to back. Its scoreboard then expects a set pulse followed at once by a clear pulse.

// File: rtl/iso_pulse_link.sv
module iso_pulse_link #(
  parameter int REFRESH_CYCLES  = 40,
  parameter int WATCHDOG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic dflt_lvl,
  output logic tx_set,
  output logic tx_clr,
  input  logic rx_set,
  input  logic rx_clr,
  output logic dout
);
  localparam int RW = $clog2(REFRESH_CYCLES);
  localparam int WW = $clog2(WATCHDOG_CYCLES);

  initial begin
    assert (WATCHDOG_CYCLES > REFRESH_CYCLES && REFRESH_CYCLES >= 2)
      else $error("R10: WATCHDOG_CYCLES must exceed REFRESH_CYCLES (>= 2)");
  end

  logic          s1, s2, lvl;
  logic [2:0]    arm;
  logic [RW-1:0] rcnt;
  logic          boot, moved, due, send;

  assign boot  = arm[1] & ~arm[2];
  assign moved = arm[2] & (s2 != lvl);
  assign due   = arm[2] & (rcnt == RW'(REFRESH_CYCLES - 1));
  assign send  = boot | moved | due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      arm    <= '0;
      lvl    <= 1'b0;
      rcnt   <= '0;
      tx_set <= 1'b0;
      tx_clr <= 1'b0;
    end else begin
      s1     <= din;
      s2     <= s1;
      arm    <= {arm[1:0], 1'b1};
      tx_set <= send & s2;
      tx_clr <= send & ~s2;
      if (send) begin
        lvl  <= s2;
        rcnt <= '0;
      end else if (arm[2]) begin
        rcnt <= rcnt + RW'(1);
      end
    end
  end

  logic          q, fault, valid, expire;
  logic [WW-1:0] wcnt;

  assign valid  = rx_set ^ rx_clr;
  assign expire = (wcnt == WW'(WATCHDOG_CYCLES - 1));
  assign dout   = fault ? dflt_lvl : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= 1'b0;
      fault <= 1'b1;
      wcnt  <= WW'(WATCHDOG_CYCLES - 1);
    end else if (valid) begin
      q     <= rx_set;
      fault <= 1'b0;
      wcnt  <= '0;
    end else if (expire) begin
      fault <= 1'b1;
    end else begin
      wcnt  <= wcnt + WW'(1);
    end
  end
endmodule

// File: rtl/iso_pulse_link_chk.sv
module iso_pulse_link_chk #(
  parameter int WATCHDOG_CYCLES = 200
) (
  input logic clk,
  input logic rst_n,
  input logic tx_set,
  input logic tx_clr,
  input logic rx_set,
  input logic rx_clr,
  input logic dflt_lvl,
  input logic dout
);
  localparam int IW = $clog2(WATCHDOG_CYCLES + 1);
  logic [IW-1:0] idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle <= IW'(WATCHDOG_CYCLES);
    else if (rx_set ^ rx_clr) idle <= '0;
    else if (idle != IW'(WATCHDOG_CYCLES)) idle <= idle + IW'(1);
  end

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n) !(tx_set && tx_clr));
  p_narrow_set_r5: assert property (@(posedge clk) disable iff (!rst_n) tx_set |=> !tx_set);
  p_narrow_clr_r5: assert property (@(posedge clk) disable iff (!rst_n) tx_clr |=> !tx_clr);
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n) (rx_set && !rx_clr) |=> dout);
  p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n) (rx_clr && !rx_set) |=> !dout);
  p_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle == IW'(WATCHDOG_CYCLES)) |-> (dout == dflt_lvl));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set && rx_clr && idle < IW'(WATCHDOG_CYCLES - 1)) |=> $stable(dout));
endmodule

bind iso_pulse_link iso_pulse_link_chk #(.WATCHDOG_CYCLES(WATCHDOG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_set(tx_set), .tx_clr(tx_clr),
  .rx_set(rx_set), .rx_clr(rx_clr), .dflt_lvl(dflt_lvl), .dout(dout)
);

// File: tb/iso_pulse_link_test.sv
module iso_pulse_link_test;
  localparam int R = 40;
  localparam int W = 200;

  logic clk = 1'b0, rst_n = 1'b0, din = 1'b0, dflt = 1'b0;
  logic lb = 1'b1, fs = 1'b0, fc = 1'b0;
  logic tx_set, tx_clr, dout, rx_set, rx_clr;
  int cyc = 0, checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { int at; bit lv; string tag; } pulse_t;
  pulse_t sb[$];
  int last = 0;
  bit cur = 1'b0;

  assign rx_set = lb ? tx_set : fs;
  assign rx_clr = lb ? tx_clr : fc;

  iso_pulse_link #(.REFRESH_CYCLES(R), .WATCHDOG_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .din(din), .dflt_lvl(dflt),
    .tx_set(tx_set), .tx_clr(tx_clr), .rx_set(rx_set), .rx_clr(rx_clr), .dout(dout));

  always #5ns clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic push(int t, bit v, string tag);
    pulse_t p;
    p.at = t; p.lv = v; p.tag = tag;
    sb.push_back(p);
    last = t;
  endtask

  task automatic idle_until(int t);
    while (last + R <= t) push(last + R, cur, "R4");
  endtask

  task automatic at(int n);
    idle_until(n + 1);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic change(bit v);
    idle_until(cyc + 2);
    din = v;
    if (v != cur) push(cyc + 3, v, "R3");
    cur = v;
  endtask

  task automatic do_reset(bit d0, bit dl);
    @(negedge clk);
    rst_n = 1'b0; lb = 1'b1; din = d0; dflt = dl; fs = 1'b0; fc = 1'b0;
    sb.delete();
    repeat (3) @(negedge clk);
    chk(tx_set == 1'b0 && tx_clr == 1'b0, "R1 tx idle in reset", {tx_set, tx_clr}, 0);
    chk(dout == dl, "R1 dout default in reset", dout, dl);
    rst_n = 1'b1;
    cur = d0;
    sb.delete();
    push(3, d0, "R2");
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (sb.size() > 0 && sb[0].at < cyc) begin
        chk(1'b0, {sb[0].tag, " missing pulse"}, 0, sb[0].at);
        void'(sb.pop_front());
      end
      if (tx_set || tx_clr) begin
        chk(!(tx_set && tx_clr), "R5 both tx high", {tx_set, tx_clr}, 1);
        if (sb.size() == 0) chk(1'b0, "R5 unexpected pulse", cyc, -1);
        else begin
          chk(sb[0].at == cyc, {sb[0].tag, " pulse cycle"}, cyc, sb[0].at);
          chk(tx_set == sb[0].lv, {sb[0].tag, " pulse kind"}, tx_set, sb[0].lv);
          void'(sb.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2ms;
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    do_reset(1'b0, 1'b0);
    at(4);  chk(dout == 1'b0, "R2 boot clear reaches dout", dout, 0);
    at(10); change(1'b1);
    at(14); chk(dout == 1'b1, "R3 rise reaches dout", dout, 1);
    at(150); change(1'b0);
    at(154); chk(dout == 1'b0, "R3 fall reaches dout", dout, 0);
    at(170); change(1'b1);
    at(211); change(1'b0);
    at(215); chk(dout == 1'b0, "R4 refresh then fall", dout, 0);
    at(400); chk(dout == 1'b0, "R4 idle level kept", dout, 0);

    lb = 1'b0;
    at(401); fs = 1'b1;
    at(402); fs = 1'b0; chk(dout == 1'b1, "R6 set pulse", dout, 1);
    at(601); chk(dout == 1'b1, "R7 not yet expired", dout, 1);
    at(602); chk(dout == 1'b0, "R7 expired to default 0", dout, 0);
    at(605); dflt = 1'b1;
    at(606); chk(dout == 1'b1, "R7 follows default", dout, 1);
    at(610); fc = 1'b1;
    at(611); fc = 1'b0; chk(dout == 1'b0, "R8 restore from clear pulse", dout, 0);
    at(620); fs = 1'b1; fc = 1'b1;
    at(621); fs = 1'b0; fc = 1'b0; chk(dout == 1'b0, "R9 conflict holds", dout, 0);
    at(810); chk(dout == 1'b0, "R9 watchdog not restarted (before)", dout, 0);
    at(811); chk(dout == 1'b1, "R9 watchdog not restarted (expiry)", dout, 1);
    at(820); fs = 1'b1; dflt = 1'b0;
    at(821); fs = 1'b0; chk(dout == 1'b1, "R8 restore from set pulse", dout, 1);
    at(1020); fs = 1'b1;
    at(1021); fs = 1'b0; chk(dout == 1'b1, "R8 pulse wins on expiry edge", dout, 1);
    at(1220); chk(dout == 1'b1, "R7 held before expiry", dout, 1);
    at(1221); chk(dout == 1'b0, "R7 expiry after last pulse", dout, 0);

    do_reset(1'b1, 1'b1);
    at(4);  chk(dout == 1'b1, "R2 boot set reaches dout", dout, 1);
    at(20); change(1'b0);
    at(24); chk(dout == 1'b0, "R3 fall after boot", dout, 0);
    at(300);
    chk(sb.size() <= 1, "R4 scoreboard drained", sb.size(), 1);
    finish_run();
  end
endmodule